// File: doc/BRIEF.md
# Sequential 32/16 Unsigned Divider with Status Flags

This block divides an unsigned 32-bit dividend by an unsigned 16-bit divisor over several clock cycles. The dividend arrives as two 16-bit halves, an upper half and a lower half. The block returns a 16-bit quotient and a 16-bit remainder in result registers. It also returns four status flags:

- a sign-bit copy of the quotient;
- a zero indication;
- a quotient-overflow indication;
- a rounding hint that is set when the doubled remainder reaches the divisor.

A one-cycle start pulse captures the operands. A one-cycle done pulse marks completion, which always comes a fixed 24 cycles later.

Two cases complete without writing the quotient and remainder registers. The first is a divisor of zero, which raises a separate exception pulse. The second is a quotient that would not fit in 16 bits. In both cases the result registers keep their previous contents, so the operand-holding registers of the host datapath are left intact. The surrounding logic uses the exception pulse to start its own trap handling.

Top module: `udiv_seq`

## Requirements
- R1: The operands are captured at the rising edge where `start_i` is high and no operation is running. Any later change on `dvd_hi_i`, `dvd_lo_i` or `dvsr_i` has no effect on that operation's results.
- R2: `done_o` is a one-cycle pulse. It is high in the cycle that follows the 24th rising edge, counting the edge that captured the operands as edge 1.
- R3: A `start_i` pulse while an operation is running is ignored. It produces no extra `done_o` and does not alter the running operation.
- R4: For a nonzero divisor with `dvd_hi_i < dvsr_i`, `quot_o` equals floor({hi,lo}/divisor) and `rem_o` equals {hi,lo} mod divisor from the `done_o` cycle onward.
- R5: On normal completion, `flag_n_o` equals bit 15 of the quotient, and `flag_z_o` is 1 exactly when the quotient is 0x0000.
- R6: On normal completion, `flag_c_o` is 1 exactly when 2*remainder >= divisor, computed without wrap (a remainder of 0x8000 or more still compares correctly).
- R7: For a nonzero divisor with `dvd_hi_i >= dvsr_i` (quotient above 0xFFFF), `flag_v_o` is 1 in the `done_o` cycle, and `quot_o` and `rem_o` keep their prior values.
- R8: On normal completion, `flag_v_o` is 0 and `dz_exc_o` is 0.
- R9: For a zero divisor, `dz_exc_o` pulses in the `done_o` cycle (same 24-cycle latency), and `quot_o` and `rem_o` keep their prior values.
- R10: After reset, `quot_o`, `rem_o`, all flags, `done_o` and `dz_exc_o` are 0.
- R11: `quot_o` and `rem_o` change only in a cycle where `done_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, sampled when idle |
| dvd_hi_i | input | 16 | Upper dividend half |
| dvd_lo_i | input | 16 | Lower dividend half |
| dvsr_i | input | 16 | Divisor |
| done_o | output | 1 | Completion pulse |
| dz_exc_o | output | 1 | Divide-by-zero exception pulse |
| quot_o | output | 16 | Quotient result register |
| rem_o | output | 16 | Remainder result register |
| flag_n_o | output | 1 | Quotient bit 15 |
| flag_z_o | output | 1 | Quotient is zero |
| flag_v_o | output | 1 | Quotient overflow |
| flag_c_o | output | 1 | Rounding hint: 2*remainder >= divisor |

## Verification
The assertions check several properties on every cycle:

- the done pulse is one cycle wide and arrives exactly 24 edges after an accepted start;
- the result registers stay frozen outside done cycles;
- the result registers stay frozen through overflow and divide-by-zero completions;
- the running partial remainder stays below the divisor.

The numeric properties are shown by the bench scenarios. These are the quotient and remainder values, the flag values at boundaries, the ignoring of a start while busy, and the independence from operand changes after capture. The boundary cases are a remainder at or above 0x8000, a high half equal to the divisor, a maximum quotient of 0xFFFF and a zero quotient.

// File: rtl/udiv_pkg.sv
package udiv_pkg;
  typedef enum logic {
    ST_IDLE,
    ST_RUN
  } div_state_e;

  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } div_flags_t;
endpackage

// File: rtl/udiv_ctrl.sv
module udiv_ctrl
  import udiv_pkg::*;
#(
  parameter int W       = 16,
  parameter int LATENCY = 24  // must be >= W + 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic load_o,
  output logic step_o,
  output logic finish_o
);
  localparam int CNT_W = $clog2(LATENCY);
  localparam logic [CNT_W-1:0] STEPS   = CNT_W'(W);
  localparam logic [CNT_W-1:0] FIN_CNT = CNT_W'(LATENCY - 2);

  div_state_e       state_q;
  logic [CNT_W-1:0] cnt_q;

  assign load_o   = start_i && (state_q == ST_IDLE);
  assign step_o   = (state_q == ST_RUN) && (cnt_q < STEPS);
  assign finish_o = (state_q == ST_RUN) && (cnt_q == FIN_CNT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else if (load_o) begin
      state_q <= ST_RUN;
      cnt_q   <= '0;
    end else if (finish_o) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else if (state_q == ST_RUN) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  AST_NO_RELOAD_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RUN && !finish_o) |=> (state_q == ST_RUN && cnt_q != '0)); // R3
endmodule

// File: rtl/udiv_datapath.sv
module udiv_datapath #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic         step_i,
  input  logic [W-1:0] hi_i,
  input  logic [W-1:0] lo_i,
  input  logic [W-1:0] dvsr_i,
  output logic [W-1:0] quot_o,
  output logic [W-1:0] rem_o,
  output logic [W-1:0] dvsr_o,
  output logic         ovf_o,
  output logic         dz_o
);
  logic [W-1:0] prem_q, quo_q, dvsr_q;
  logic         ovf_q, dz_q;
  logic [W:0]   trial, diff;
  logic         fits;

  // restoring step: shift next dividend bit into the partial remainder
  assign trial = {prem_q, quo_q[W-1]};
  assign diff  = trial - {1'b0, dvsr_q};
  assign fits  = trial >= {1'b0, dvsr_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prem_q <= '0;
      quo_q  <= '0;
      dvsr_q <= '0;
      ovf_q  <= 1'b0;
      dz_q   <= 1'b0;
    end else if (load_i) begin
      prem_q <= hi_i;
      quo_q  <= lo_i;
      dvsr_q <= dvsr_i;
      dz_q   <= (dvsr_i == '0);
      ovf_q  <= (dvsr_i != '0) && (hi_i >= dvsr_i);
    end else if (step_i && !ovf_q && !dz_q) begin
      prem_q <= fits ? diff[W-1:0] : trial[W-1:0];
      quo_q  <= {quo_q[W-2:0], fits};
    end
  end

  assign quot_o = quo_q;
  assign rem_o  = prem_q;
  assign dvsr_o = dvsr_q;
  assign ovf_o  = ovf_q;
  assign dz_o   = dz_q;

  AST_PREM_BELOW_DVSR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !ovf_q && !dz_q) |-> (prem_q < dvsr_q)); // R4
endmodule

// File: rtl/udiv_flags.sv
module udiv_flags
  import udiv_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0] quot_i,
  input  logic [W-1:0] rem_i,
  input  logic [W-1:0] dvsr_i,
  output div_flags_t   flags_o
);
  // doubled remainder kept at W+1 bits so it cannot wrap
  logic [W:0] rem_x2;
  assign rem_x2 = {rem_i, 1'b0};

  always_comb begin
    flags_o.n = quot_i[W-1];
    flags_o.z = (quot_i == '0);
    flags_o.v = 1'b0;
    flags_o.c = (rem_x2 >= {1'b0, dvsr_i});
  end
endmodule

// File: rtl/udiv_seq.sv
module udiv_seq
  import udiv_pkg::*;
#(
  parameter int W       = 16,
  parameter int LATENCY = 24
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [W-1:0] dvd_hi_i,
  input  logic [W-1:0] dvd_lo_i,
  input  logic [W-1:0] dvsr_i,
  output logic         done_o,
  output logic         dz_exc_o,
  output logic [W-1:0] quot_o,
  output logic [W-1:0] rem_o,
  output logic         flag_n_o,
  output logic         flag_z_o,
  output logic         flag_v_o,
  output logic         flag_c_o
);
  localparam int LAT_W = $clog2(LATENCY + 1);

  logic         load, step, finish;
  logic [W-1:0] dp_quot, dp_rem, dp_dvsr;
  logic         dp_ovf, dp_dz;
  div_flags_t   new_flags, flags_q;
  logic [W-1:0] quot_q, rem_q;
  logic         done_q, dz_exc_q;

  udiv_ctrl #(.W(W), .LATENCY(LATENCY)) u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .load_o  (load),
    .step_o  (step),
    .finish_o(finish)
  );

  udiv_datapath #(.W(W)) u_dp (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(load),
    .step_i(step),
    .hi_i  (dvd_hi_i),
    .lo_i  (dvd_lo_i),
    .dvsr_i(dvsr_i),
    .quot_o(dp_quot),
    .rem_o (dp_rem),
    .dvsr_o(dp_dvsr),
    .ovf_o (dp_ovf),
    .dz_o  (dp_dz)
  );

  udiv_flags #(.W(W)) u_flags (
    .quot_i (dp_quot),
    .rem_i  (dp_rem),
    .dvsr_i (dp_dvsr),
    .flags_o(new_flags)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      quot_q   <= '0;
      rem_q    <= '0;
      flags_q  <= '0;
      done_q   <= 1'b0;
      dz_exc_q <= 1'b0;
    end else begin
      done_q   <= finish;
      dz_exc_q <= finish && dp_dz;
      if (finish && !dp_dz) begin
        if (dp_ovf) begin
          flags_q.v <= 1'b1;  // results held, other flags don't-care
        end else begin
          quot_q  <= dp_quot;
          rem_q   <= dp_rem;
          flags_q <= new_flags;
        end
      end
    end
  end

  assign done_o   = done_q;
  assign dz_exc_o = dz_exc_q;
  assign quot_o   = quot_q;
  assign rem_o    = rem_q;
  assign flag_n_o = flags_q.n;
  assign flag_z_o = flags_q.z;
  assign flag_v_o = flags_q.v;
  assign flag_c_o = flags_q.c;

  // latency window counter for the checks below
  logic [LAT_W-1:0] lat_cnt_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          lat_cnt_q <= '0;
    else if (load)                        lat_cnt_q <= LAT_W'(1);
    else if (done_o)                      lat_cnt_q <= '0;
    else if (lat_cnt_q != '0)             lat_cnt_q <= lat_cnt_q + 1'b1;
  end

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R2
  AST_DONE_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (lat_cnt_q == LAT_W'(LATENCY))); // R2
  AST_DZ_WITH_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dz_exc_o |-> done_o); // R9
  AST_DZ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dz_exc_o |-> ($stable(quot_o) && $stable(rem_o))); // R9
  AST_OVF_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !dz_exc_o && flag_v_o) |-> ($stable(quot_o) && $stable(rem_o))); // R7
  AST_QUIET_RESULTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> ($stable(quot_o) && $stable(rem_o))); // R11
endmodule

// File: tb/udiv_seq_test.sv
module udiv_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int LAT        = 24;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] hi = '0, lo = '0, dv = '0;
  logic        done, dz_exc, fn, fz, fv, fc;
  logic [15:0] quot, rem;

  int n_chk = 0, n_err = 0, cyc = 0;
  bit finished = 1'b0;

  typedef struct {
    logic [15:0] hi, lo, dv;
    int          st;
  } item_t;
  item_t sb[$];

  logic [15:0] m_q = '0, m_r = '0;
  bit prev_done = 1'b0;

  udiv_seq uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .dvd_hi_i(hi), .dvd_lo_i(lo), .dvsr_i(dv),
    .done_o(done), .dz_exc_o(dz_exc), .quot_o(quot), .rem_o(rem),
    .flag_n_o(fn), .flag_z_o(fz), .flag_v_o(fv), .flag_c_o(fc)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // monitor: pop expected item on each done and compare
  always @(negedge clk) begin
    if (rst_n) begin
      chk(!(prev_done && done), "R2", "done wider than one cycle", 32'(done), 0);
      prev_done = done;
      if (done) begin
        if (sb.size() == 0) begin
          chk(1'b0, "R3", "done with no accepted start", 1, 0);
        end else begin
          item_t it;
          logic [31:0] dvd, eq, er;
          it  = sb.pop_front();
          dvd = {it.hi, it.lo};
          chk(cyc - it.st == LAT, "R2", "latency", 32'(cyc - it.st), LAT);
          if (it.dv == 0) begin
            chk(dz_exc == 1'b1, "R9", "dz exception", 32'(dz_exc), 1);
            chk(quot == m_q && rem == m_r, "R9", "results held on dz",
                {quot, rem}, {m_q, m_r});
          end else if (it.hi >= it.dv) begin
            chk(fv == 1'b1, "R7", "overflow flag", 32'(fv), 1);
            chk(quot == m_q && rem == m_r, "R7", "results held on overflow",
                {quot, rem}, {m_q, m_r});
          end else begin
            eq = dvd / {16'h0, it.dv};
            er = dvd % {16'h0, it.dv};
            chk(quot == eq[15:0], "R4 R1", "quotient", 32'(quot), eq);
            chk(rem == er[15:0], "R4 R1", "remainder", 32'(rem), er);
            chk(fn == eq[15], "R5", "N flag", 32'(fn), 32'(eq[15]));
            chk(fz == (eq == 0), "R5", "Z flag", 32'(fz), 32'(eq == 0));
            chk(fc == ((er << 1) >= {16'h0, it.dv}), "R6", "C flag", 32'(fc),
                32'((er << 1) >= {16'h0, it.dv}));
            chk(fv == 1'b0 && dz_exc == 1'b0, "R8", "V and dz clear",
                {fv, dz_exc}, 0);
            m_q = eq[15:0];
            m_r = er[15:0];
          end
        end
      end
    end
  end

  // driver: start one op, scramble operands afterwards, optionally poke start
  task automatic run_op(input logic [15:0] h, input logic [15:0] l,
                        input logic [15:0] d, input bit poke);
    item_t it;
    @(negedge clk);
    hi = h; lo = l; dv = d; start = 1'b1;
    it.hi = h; it.lo = l; it.dv = d; it.st = cyc;
    sb.push_back(it);
    @(negedge clk);
    start = 1'b0;
    hi = ~h; lo = l ^ 16'h5a5a; dv = d + 16'h1;  // R1: must not matter
    if (poke) begin  // R3: start while busy
      repeat (4) @(negedge clk);
      hi = 16'h0; lo = 16'h1; dv = 16'h1; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (sb.size() != 0) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(quot == 0 && rem == 0, "R10", "results after reset", {quot, rem}, 0);
    chk({fn, fz, fv, fc, done, dz_exc} == 0, "R10", "flags after reset",
        32'({fn, fz, fv, fc, done, dz_exc}), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(done == 1'b0, "R10", "no done when idle", 32'(done), 0);

    run_op(16'h0000, 16'd100, 16'd7, 1'b0);
    run_op(16'h0001, 16'h0000, 16'h0003, 1'b0);
    run_op(16'h0000, 16'd5, 16'd10, 1'b0);       // zero quotient, C at equality
    run_op(16'h8000, 16'h0000, 16'hFFFF, 1'b0);  // remainder 0x8000, R6 wrap case
    run_op(16'h0005, 16'h1234, 16'h0005, 1'b0);  // R7 hi == divisor
    run_op(16'hFFFF, 16'hFFFF, 16'h0001, 1'b0);  // R7 large overflow
    run_op(16'hFFFE, 16'hFFFF, 16'hFFFF, 1'b0);  // quotient 0xFFFF
    run_op(16'h1234, 16'h5678, 16'h0000, 1'b0);  // R9 divide by zero
    run_op(16'h7FFF, 16'hFFFF, 16'hFFFF, 1'b1);  // R3 poke while busy
    run_op(16'h0000, 16'hFFFF, 16'h0100, 1'b0);
    repeat (40) @(negedge clk);                   // catch stray done
    chk(sb.size() == 0, "R3", "scoreboard drained", sb.size(), 0);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule